// File: doc/BRIEF.md
# Pending Acknowledgement Tracker for a Multicast Edge Interrupt

This block follows one edge-triggered interrupt line that is sent to several destinations at once. The line normally cannot tell whether an earlier edge is still unserviced. The block adds that knowledge. When the delivery logic reports a delivery, it passes in the set of destinations that accepted the interrupt and the vector they were given. The block stores one pending bit and one vector per destination. It also keeps a count of the destinations that have not yet acknowledged.

Acknowledgement messages carry a destination number and a vector. One of them retires a destination only when that destination is pending and the vector matches the one it stored. While any acknowledgement is outstanding, the block reports that a new assertion of the line would be coalesced, and it ignores delivery requests. Routing and the choice of destinations stay outside the block.

The controller has two states:
- `TRK_IDLE`: nothing is outstanding.
- `TRK_PENDING`: at least one destination still owes an acknowledgement.

The transitions are:
- `IDLE->PENDING`: a delivery with a non-empty accepted set.
- `IDLE->IDLE`: a delivery with an empty accepted set, or no delivery at all.
- `PENDING->IDLE`: the last outstanding acknowledgement is retired.
- `PENDING->PENDING`: any other cycle.

Top module: `eoi_pending_tracker`

## Requirements
- R1: After reset (asynchronous, active low) the pending count is 0, every pending bit is 0 and `coalesced` is 0.
- R2: A delivery request taken while the count is 0 has these effects, visible one clock later: the pending set equals `dlv_map` (bit i stands for destination i), the count equals the number of ones in `dlv_map`, and each accepting destination stores `dlv_vector`.
- R3: An acknowledgement retires a destination when `eoi_dest` names a pending destination and `eoi_vector` equals that destination's stored vector. Retiring clears the destination's bit and lowers the count by one, one clock later.
- R4: An acknowledgement whose destination is not pending, or whose vector differs from the stored one, changes neither the pending set nor the count.
- R5: `coalesced` is 1 exactly when the pending count is non-zero. It follows the count with no additional register.
- R6: A delivery request made while `coalesced` is 1 is dropped. This includes a cycle in which an acknowledgement retires the last pending destination: that acknowledgement is applied, and the delivery is not.
- R7: A delivery whose accepted set is empty leaves the count at 0 and `coalesced` at 0.
- R8: The count always equals the number of set pending bits, so it can never drop below zero. A count of 16 is representable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dlv_valid | input | 1 | Delivery of the line is requested this cycle |
| dlv_map | input | N_DEST | Destinations that accepted the delivery |
| dlv_vector | input | VEC_W | Vector given to the accepting destinations |
| eoi_valid | input | 1 | An acknowledgement arrives this cycle |
| eoi_dest | input | DEST_W | Destination sending the acknowledgement |
| eoi_vector | input | VEC_W | Vector being acknowledged |
| coalesced | output | 1 | A new assertion would be coalesced |
| pend_count | output | CNT_W | Number of outstanding acknowledgements |
| pend_map | output | N_DEST | Pending bit for each destination |

## Verification
The bench uses the default parameters: 16 destinations and 8-bit vectors. With these values an all-ones accepted set drives the count to its full value of 16, the top destination number 15 is used, and the count's widest bit is exercised. Directed sequences cover the corner cases:
- wrong-vector acknowledgements;
- acknowledgements from destinations that are not pending;
- an empty accepted set;
- a delivery in the same cycle as the final retirement;
- a vector that changes between deliveries.

A long run of random traffic then biases acknowledgements toward pending destinations.

// File: rtl/eoi_trk_pkg.sv
package eoi_trk_pkg;
    typedef enum logic [0:0] {
        TRK_IDLE    = 1'b0,
        TRK_PENDING = 1'b1
    } trk_state_e;
endpackage

// File: rtl/eoi_ones_count.sv
module eoi_ones_count #(
    parameter int W  = 16,
    parameter int CW = 5
) (
    input  logic [W-1:0]  bits_in,
    output logic [CW-1:0] ones
);
    always_comb begin
        ones = '0;
        for (int i = 0; i < W; i++) begin
            ones = ones + CW'(bits_in[i]);
        end
    end
endmodule

// File: rtl/eoi_slot_bank.sv
module eoi_slot_bank #(
    parameter int N  = 16,
    parameter int VW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [N-1:0]  load_map,
    input  logic [VW-1:0] load_vec,
    input  logic [N-1:0]  retire,
    output logic [N-1:0]  slot_map,
    output logic [VW-1:0] slot_vec [N]
);
    for (genvar g = 0; g < N; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_map[g] <= 1'b0;
                slot_vec[g] <= '0;
            end else if (load) begin
                slot_map[g] <= load_map[g];
                if (load_map[g]) begin
                    slot_vec[g] <= load_vec;
                end
            end else if (retire[g]) begin
                slot_map[g] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/eoi_pending_tracker.sv
module eoi_pending_tracker
    import eoi_trk_pkg::*;
#(
    parameter  int N_DEST = 16,
    parameter  int VEC_W  = 8,
    localparam int DEST_W = (N_DEST > 1) ? $clog2(N_DEST) : 1,
    localparam int CNT_W  = $clog2(N_DEST + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dlv_valid,
    input  logic [N_DEST-1:0] dlv_map,
    input  logic [VEC_W-1:0]  dlv_vector,
    input  logic              eoi_valid,
    input  logic [DEST_W-1:0] eoi_dest,
    input  logic [VEC_W-1:0]  eoi_vector,
    output logic              coalesced,
    output logic [CNT_W-1:0]  pend_count,
    output logic [N_DEST-1:0] pend_map
);
    trk_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [CNT_W-1:0]  accept_ones;
    logic [N_DEST-1:0] slot_map;
    logic [VEC_W-1:0]  slot_vec [N_DEST];
    logic [N_DEST-1:0] retire_oh;
    logic              hit;
    logic              take;

    eoi_ones_count #(.W(N_DEST), .CW(CNT_W)) u_ones (
        .bits_in (dlv_map),
        .ones    (accept_ones)
    );

    always_comb begin
        hit = 1'b0;
        if (eoi_valid && (int'(eoi_dest) < N_DEST)) begin
            hit = slot_map[eoi_dest] && (slot_vec[eoi_dest] == eoi_vector);
        end
        retire_oh = '0;
        if (hit) begin
            retire_oh[eoi_dest] = 1'b1;
        end
        take = dlv_valid && (state_q == TRK_IDLE);
    end

    eoi_slot_bank #(.N(N_DEST), .VW(VEC_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (take),
        .load_map (dlv_map),
        .load_vec (dlv_vector),
        .retire   (retire_oh),
        .slot_map (slot_map),
        .slot_vec (slot_vec)
    );

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            TRK_IDLE: begin
                if (take) begin
                    cnt_d = accept_ones;
                    if (accept_ones != '0) begin
                        state_d = TRK_PENDING;
                    end
                end
            end
            TRK_PENDING: begin
                if (hit) begin
                    cnt_d = cnt_q - 1'b1;
                    if (cnt_q == CNT_W'(1)) begin
                        state_d = TRK_IDLE;
                    end
                end
            end
            default: begin
                state_d = TRK_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TRK_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        coalesced  = (state_q == TRK_PENDING);
        pend_count = cnt_q;
        pend_map   = slot_map;
    end

    a_r5_coalesced_tracks_count: assert property (@(posedge clk) disable iff (!rst_n)
        coalesced == (pend_count != '0));

    a_r8_count_matches_map: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pend_count) == $countones(pend_map));

    a_r2_load_sets_count: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && !coalesced) |=> int'(pend_count) == $countones($past(dlv_map)));

    a_r3_retire_decrements: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> int'(pend_count) == int'($past(pend_count)) - 1);

    a_r4_miss_keeps_map: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_valid && !hit && !(dlv_valid && !coalesced)) |=> $stable(pend_map));

    a_r6_no_load_while_coalesced: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && coalesced) |=> int'(pend_count) <= int'($past(pend_count)));
endmodule

// File: tb/test_eoi_pending_tracker.sv
module test_eoi_pending_tracker;
    localparam int N  = 16;
    localparam int VW = 8;
    localparam int DW = 4;
    localparam int CW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dlv_valid = 1'b0;
    logic [N-1:0]  dlv_map = '0;
    logic [VW-1:0] dlv_vector = '0;
    logic          eoi_valid = 1'b0;
    logic [DW-1:0] eoi_dest = '0;
    logic [VW-1:0] eoi_vector = '0;
    logic          coalesced;
    logic [CW-1:0] pend_count;
    logic [N-1:0]  pend_map;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    int       m_cnt = 0;
    bit [N-1:0] m_map = '0;
    int       m_vec [N];

    always #4 clk = ~clk;

    eoi_pending_tracker #(.N_DEST(N), .VEC_W(VW)) i_eoi_pending_tracker (
        .clk(clk), .rst_n(rst_n), .dlv_valid(dlv_valid), .dlv_map(dlv_map),
        .dlv_vector(dlv_vector), .eoi_valid(eoi_valid), .eoi_dest(eoi_dest),
        .eoi_vector(eoi_vector), .coalesced(coalesced), .pend_count(pend_count),
        .pend_map(pend_map)
    );

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: actual cycles %0d expected below 20000", cycles);
            summary();
        end
    end

    task automatic compare(string tag);
        checks++;
        if (int'(pend_count) != m_cnt) begin
            errors++;
            $display("FAIL %s count: actual %0d expected %0d", tag, pend_count, m_cnt);
        end
        checks++;
        if (pend_map !== m_map) begin
            errors++;
            $display("FAIL %s map: actual %h expected %h", tag, pend_map, m_map);
        end
        checks++;
        if (coalesced !== (m_cnt != 0)) begin
            errors++;
            $display("FAIL R5 %s coalesced: actual %0b expected %0b", tag, coalesced, m_cnt != 0);
        end
    endtask

    // drive at negedge, model advance, wait one edge, compare at next negedge
    task automatic step(bit dv, bit [N-1:0] mp, int vec, bit ev, int ed, int evec, string tag);
        bit coal;
        bit hit;
        dlv_valid  = dv;
        dlv_map    = mp;
        dlv_vector = VW'(vec);
        eoi_valid  = ev;
        eoi_dest   = DW'(ed);
        eoi_vector = VW'(evec);
        coal = (m_cnt != 0);
        hit  = ev && m_map[ed] && (m_vec[ed] == evec);
        if (hit) begin
            m_map[ed] = 1'b0;
            m_cnt--;
        end
        if (dv && !coal) begin
            m_map = mp;
            m_cnt = $countones(mp);
            for (int i = 0; i < N; i++) if (mp[i]) m_vec[i] = vec;
        end
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        for (int i = 0; i < N; i++) m_vec[i] = 0;
        repeat (3) @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1");

        // full fan-out, count reaches 16
        step(1, 16'hFFFF, 8'h41, 0, 0, 0, "R2_full");
        step(0, 0, 0, 1, 15, 8'h42, "R4_wrongvec");
        step(1, 16'h0001, 8'h10, 0, 0, 0, "R6_coalesced_drop");
        for (int d = 0; d < N - 1; d++) step(0, 0, 0, 1, d, 8'h41, "R3_retire");
        step(0, 0, 0, 1, 3, 8'h41, "R4_not_pending");
        // last retire together with a delivery: delivery dropped
        step(1, 16'h00F0, 8'h22, 1, 15, 8'h41, "R6_same_cycle");
        step(1, 16'h0000, 8'h22, 0, 0, 0, "R7_empty");
        step(1, 16'h8001, 8'h55, 0, 0, 0, "R2_two");
        step(0, 0, 0, 1, 0, 8'h55, "R3_first");
        step(0, 0, 0, 1, 15, 8'h55, "R3_last");
        step(1, 16'h0001, 8'h66, 0, 0, 0, "R2_newvec");
        step(0, 0, 0, 1, 0, 8'h55, "R4_stale_vec");
        step(0, 0, 0, 1, 0, 8'h66, "R3_newvec");

        for (int k = 0; k < 600; k++) begin
            bit dv = ($urandom % 4) == 0;
            bit ev = ($urandom % 2) == 0;
            int ed = $urandom % N;
            int ev_vec;
            bit [N-1:0] mp = N'($urandom) & N'($urandom);
            int vec = $urandom % 4;
            ev_vec = (($urandom % 4) != 0) ? m_vec[ed] : int'($urandom % 4);
            if (m_map != 0 && ($urandom % 2) == 0) begin
                for (int i = 0; i < N; i++) if (m_map[(ed + i) % N]) begin
                    ed = (ed + i) % N;
                    ev_vec = m_vec[ed];
                    break;
                end
            end
            step(dv, mp, vec, ev, ed, ev_vec, "R8_random");
        end

        rst_n = 1'b0;
        m_cnt = 0;
        m_map = '0;
        #1;
        compare("R1_midrun");
        summary();
    end
endmodule